// File: doc/BRIEF.md
# SPI Register-Access Slave

This block sits between an external SPI master and a bank of byte-wide control registers inside a peripheral controller. The master lowers chip select and sends a command byte first. That byte names one of 21 registers, says whether the bytes that follow are written or read, and can carry an acknowledge flag. The flag sets a fixed bit in the stall register as a side effect. Every data byte that follows in the same frame accesses the same register.

The block runs in full-duplex mode. While the command byte shifts in, the block shifts out a byte of eight interrupt status bits, so the master sees the pending interrupts on every access at no extra cost. Register 20 carries the levels of four general-purpose inputs in its upper nibble. Those inputs pass through a synchronizer, and the master cannot write those bits.

The SPI pins are sampled with the fast system clock. They are synchronized, and their edges are detected in that clock domain, so SCK must run at no more than about one twelfth of the system clock. The stored register contents go to the rest of the controller on one flat vector.

Top module: `spi_reg_slave`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00, `reg_flat` is all zeros and `spi_miso` is 0.
- R2: `spi_miso` is 0 whenever `spi_cs_n` is high.
- R3: SPI mode 0 is used: MOSI is sampled on SCK rising edges and MISO changes after falling edges, most-significant bit first. During the command byte, MISO carries `irq_status` sampled when chip select falls, with `irq_status[7]` shifted out first.
- R4: The command byte is decoded as follows: bits 7..3 hold the register number, bit 2 is 0, bit 1 is the direction (1 = write) and bit 0 is the acknowledge flag. A write stores the data byte in the addressed register.
- R5: With direction 0, each data byte slot returns the addressed register's current value MSB first. During write data bytes MISO returns 0x00.
- R6: A command with bit 0 = 1 sets bit 0 of register 9 before any data byte of that frame is read, and leaves the other bits alone. A write to register 9 later in that frame overwrites the whole byte.
- R7: In a frame with several data bytes, every data byte accesses the same register. A write burst leaves the last byte written.
- R8: Register numbers 21 to 31 read as 0x00, and writes to them change no register.
- R9: Register 20 bits 7..4 read the synchronized levels of `gp_in[3:0]`, with `gp_in[3]` at bit 7, and follow changes between bytes of a burst. Writes to register 20 store only bits 3..0.
- R10: Raising chip select part-way through a byte discards the partial byte and resets the bit count, so the next frame starts with a fresh command byte.
- R11: `reg_flat[8n+7:8n]` holds the stored value of register n. Register 20's stored upper nibble is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 12x the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low, frames one command and its data |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, 0 while deselected |
| irq_status | input | 8 | Interrupt status bits returned during the command byte |
| gp_in | input | 4 | Asynchronous general-purpose input levels |
| reg_flat | output | 168 | Stored contents of all 21 registers, register n at bits 8n+7:8n |

## Verification
Two things can land in the same frame window. The acknowledge side effect of a command updates register 9 in the clock cycle after the command byte completes. The read of that same register is loaded into the shift path a few cycles later. A command that reads register 9 with the acknowledge flag set therefore provokes both. The bench judges it by expecting the returned byte to already include the set bit. A second case is a read burst of register 20 in which `gp_in` changes between bytes. This pits the synchronizer update against the byte load, and the bench expects the second byte to show the new levels.

// File: rtl/spi_regs_pkg.sv
// Package: shared constants and the command-byte layout for the SPI
// register-access slave. Assumes 8-bit registers and a fixed command format.
package spi_regs_pkg;
    localparam int BYTE_W     = 8;
    localparam int CMD_ADDR_W = 5;

    // Command byte: register number, reserved zero, direction, acknowledge flag
    typedef struct packed {
        logic [CMD_ADDR_W-1:0] addr;
        logic                  rsvd;
        logic                  dir_wr;
        logic                  ack;
    } cmd_t;
endpackage

// File: rtl/cdc_sync.sv
// Module: multi-stage flip-flop synchronizer for a bus of independent
// single-bit signals. Assumes each bit may be sampled on its own (no
// multi-bit coherence is needed). The reset value is a parameter.
module cdc_sync #(
    parameter int             WIDTH   = 1,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous input through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: SPI mode-0 frame controller. Works on synchronized SCK, CS and
// MOSI in the system clock domain. It counts bits, decodes the command byte,
// pulses write and acknowledge strobes, and runs the MISO shift register
// (status byte first, then read data). Assumes SCK is slow enough that every
// level lasts several system clocks.
module spi_frame_ctrl
    import spi_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_s,
    input  logic                  cs_n_s,
    input  logic                  cs_n_raw,
    input  logic                  mosi_s,
    input  logic [BYTE_W-1:0]     status_in,
    input  logic [BYTE_W-1:0]     rd_data,
    output logic                  miso,
    output logic [CMD_ADDR_W-1:0] reg_addr,
    output logic                  wr_en,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  ack_set
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_d, cs_d;
    logic              sck_rise, sck_fall, frame_start;
    logic [CNT_W-1:0]  bit_cnt;
    logic              in_cmd;
    logic [BYTE_W-2:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    cmd_t              cmd_q;

    assign sck_rise    = sck_s & ~sck_d & ~cs_n_s;
    assign sck_fall    = ~sck_s & sck_d & ~cs_n_s;
    assign frame_start = ~cs_n_s & cs_d;
    assign rx_byte     = {rx_q, mosi_s};
    assign byte_done   = sck_rise && (bit_cnt == CNT_W'(BYTE_W-1));

    // Remember previous SCK and CS levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    // Receive path: bit counter, input shift register, command capture, strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_cmd  <= 1'b1;
            rx_q    <= '0;
            cmd_q   <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            ack_set <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            ack_set <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
                in_cmd  <= 1'b1;
                rx_q    <= '0;
            end else if (sck_rise) begin
                rx_q    <= rx_byte[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    if (in_cmd) begin
                        cmd_q   <= cmd_t'(rx_byte);
                        in_cmd  <= 1'b0;
                        ack_set <= rx_byte[0];
                    end else if (cmd_q.dir_wr) begin
                        wr_en   <= 1'b1;
                        wr_data <= rx_byte;
                    end
                end
            end
        end
    end

    // Transmit path: load status at frame start, load read data at byte borders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (cs_n_s) begin
            tx_q <= '0;
        end else if (frame_start) begin
            tx_q <= status_in;
        end else if (sck_fall) begin
            if (bit_cnt == '0 && !in_cmd)
                tx_q <= cmd_q.dir_wr ? '0 : rd_data;
            else
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso     = tx_q[BYTE_W-1] & ~cs_n_raw;
    assign reg_addr = cmd_q.addr;

    // R2: the shift register is emptied while deselected
    assert_tx_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (tx_q == '0));
    // R3: status byte captured at frame start
    assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tx_q == $past(status_in)));
    // R10: bit count restarts whenever chip select is high
    assert_cnt_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0));
    // R4: a write strobe and an acknowledge strobe never coincide
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, ack_set}));
endmodule

// File: rtl/spi_reg_file.sv
// Module: register bank of NUM_REGS bytes with one write port, a
// combinational read port, an acknowledge-bit set input and a read-only
// general-purpose input field. Assumes write and acknowledge strobes never
// coincide. Out-of-range addresses read zero and ignore writes.
module spi_reg_file
    import spi_regs_pkg::*;
#(
    parameter int NUM_REGS   = 21,
    parameter int GP_W       = 4,
    parameter int GP_ADDR    = 20,
    parameter int STALL_ADDR = 9,
    parameter int ACK_BIT    = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [GP_W-1:0]              gp_in,
    input  logic [CMD_ADDR_W-1:0]        addr,
    input  logic                         wr_en,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic                         ack_set,
    output logic [BYTE_W-1:0]            rd_data,
    output logic [NUM_REGS*BYTE_W-1:0]   reg_flat
);
    localparam logic [BYTE_W-1:0] GP_MASK = {{GP_W{1'b0}}, {(BYTE_W-GP_W){1'b1}}};

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic [GP_W-1:0]                 gp_s;
    logic                            addr_ok;

    cdc_sync #(.WIDTH(GP_W), .STAGES(2), .RST_VAL('0)) u_gp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gp_in),
        .q     (gp_s)
    );

    assign addr_ok = (int'(addr) < NUM_REGS);

    // Register updates: data writes (masked for the input field) and ack set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en && addr == CMD_ADDR_W'(i))
                    regs[i] <= (i == GP_ADDR) ? (wr_data & GP_MASK) : wr_data;
            end
            if (ack_set) regs[STALL_ADDR][ACK_BIT] <= 1'b1;
        end
    end

    // Read mux: stored byte, live input field for the GP register, zero if unmapped
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == CMD_ADDR_W'(i)) rd_data = regs[i];
        end
        if (addr == CMD_ADDR_W'(GP_ADDR))
            rd_data[BYTE_W-1 -: GP_W] = gp_s;
        if (!addr_ok) rd_data = '0;
    end

    assign reg_flat = regs;

    // R6: the acknowledge flag lands in the stall register
    assert_ack_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_set |=> regs[STALL_ADDR][ACK_BIT]);
    // R8: writes to unmapped addresses leave the bank untouched
    assert_oob_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_ok) |=> $stable(regs));
    // R9: low nibble of the GP register is writable
    assert_gp_low_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CMD_ADDR_W'(GP_ADDR)) |=>
        (regs[GP_ADDR][BYTE_W-GP_W-1:0] == $past(wr_data[BYTE_W-GP_W-1:0])));
    // R4: ordinary writes store the full byte
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && addr != CMD_ADDR_W'(GP_ADDR)) |=>
        (regs[$past(addr)] == $past(wr_data)));
endmodule

// File: rtl/spi_reg_slave.sv
// Module: top of the SPI register-access slave. It synchronizes the SPI
// pins into the system clock and connects the frame controller to the
// register bank. Assumes SCK runs at no more than 1/12 of clk.
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int NUM_REGS   = 21,
    parameter int GP_W       = 4,
    parameter int GP_ADDR    = 20,
    parameter int STALL_ADDR = 9,
    parameter int ACK_BIT    = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sck,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [BYTE_W-1:0]          irq_status,
    input  logic [GP_W-1:0]            gp_in,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat
);
    logic                  sck_s, cs_n_s, mosi_s;
    logic [CMD_ADDR_W-1:0] reg_addr;
    logic                  wr_en, ack_set;
    logic [BYTE_W-1:0]     wr_data, rd_data;

    cdc_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     ({sck_s, cs_n_s, mosi_s})
    );

    spi_frame_ctrl u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .cs_n_s    (cs_n_s),
        .cs_n_raw  (spi_cs_n),
        .mosi_s    (mosi_s),
        .status_in (irq_status),
        .rd_data   (rd_data),
        .miso      (spi_miso),
        .reg_addr  (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ack_set   (ack_set)
    );

    spi_reg_file #(
        .NUM_REGS   (NUM_REGS),
        .GP_W       (GP_W),
        .GP_ADDR    (GP_ADDR),
        .STALL_ADDR (STALL_ADDR),
        .ACK_BIT    (ACK_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .gp_in    (gp_in),
        .addr     (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ack_set  (ack_set),
        .rd_data  (rd_data),
        .reg_flat (reg_flat)
    );
endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
    localparam int HALF = 6;
    localparam int NV   = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic         miso;
    logic [7:0]   irq = 8'h00;
    logic [3:0]   gp = 4'h6;
    logic [167:0] flat;
    int           nchk = 0, nfail = 0;
    int           cyc = 0;

    always #2.5 clk = ~clk;

    spi_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .irq_status(irq),
        .gp_in(gp), .reg_flat(flat)
    );

    // {command, write byte, expected returned data byte}
    localparam logic [23:0] VECS [NV] = '{
        {8'h1A, 8'hA5, 8'h00},  // write reg 3
        {8'h18, 8'h00, 8'hA5},  // read reg 3
        {8'h02, 8'h3C, 8'h00},  // write reg 0
        {8'h00, 8'h00, 8'h3C},  // read reg 0
        {8'h9A, 8'hFF, 8'h00},  // write reg 19
        {8'h98, 8'h00, 8'hFF},  // read reg 19
        {8'h4A, 8'h40, 8'h00},  // write reg 9
        {8'h48, 8'h00, 8'h40},  // read reg 9
        {8'hA2, 8'hFA, 8'h00},  // write reg 20
        {8'hA0, 8'h00, 8'h6A},  // read reg 20: gp 6, low A
        {8'hAA, 8'h77, 8'h00},  // write reg 21 (ignored)
        {8'hA8, 8'h00, 8'h00},  // read reg 21
        {8'hFA, 8'h55, 8'h00},  // write reg 31 (ignored)
        {8'hF8, 8'h00, 8'h00},  // read reg 31
        {8'h00, 8'h00, 8'h3C},  // reg 0 unchanged
        {8'h49, 8'h00, 8'h41},  // read reg 9 with ack flag
        {8'h4B, 8'h80, 8'h00},  // write reg 9 with ack flag
        {8'h48, 8'h00, 8'h80}   // write overrode ack bit
    };

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [167:0] act, input logic [167:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wclk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wclk(8);
    endtask

    task automatic cs_high();
        wclk(3);
        cs_n = 1'b1;
        wclk(8);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, r0, r1, r2;
        wclk(5);
        rst_n = 1'b1;
        wclk(4);
        check("R1 reg_flat after reset", flat, '0);
        check("R1 miso after reset", {167'b0, miso}, 168'b0);

        for (int v = 0; v < NV; v++) begin
            irq = VECS[v][23:16] ^ 8'h5A ^ 8'(v);
            cs_low();
            shift_bits(VECS[v][23:16], 8, st);
            shift_bits(VECS[v][15:8], 8, r0);
            cs_high();
            check("R3 status byte", {160'b0, st}, {160'b0, VECS[v][23:16] ^ 8'h5A ^ 8'(v)});
            check("R4 R5 R6 R8 R9 data byte", {160'b0, r0}, {160'b0, VECS[v][7:0]});
        end

        // R11: flat vector matches stored values; reg 20 upper nibble stored 0
        check("R11 reg3", {160'b0, flat[3*8 +: 8]}, {160'b0, 8'hA5});
        check("R11 reg19", {160'b0, flat[19*8 +: 8]}, {160'b0, 8'hFF});
        check("R9 reg20 stored", {160'b0, flat[20*8 +: 8]}, {160'b0, 8'h0A});
        check("R6 reg9 stored", {160'b0, flat[9*8 +: 8]}, {160'b0, 8'h80});

        // R2: MISO stays low while deselected even with status set
        irq = 8'hFF;
        wclk(4);
        check("R2 idle miso", {167'b0, miso}, 168'b0);

        // R7: write burst keeps last byte; read burst repeats it
        cs_low();
        shift_bits(8'h2A, 8, st);
        shift_bits(8'h11, 8, r0);
        shift_bits(8'h22, 8, r0);
        shift_bits(8'h33, 8, r0);
        cs_high();
        check("R7 burst write last", {160'b0, flat[5*8 +: 8]}, {160'b0, 8'h33});
        check("R8 reg0 kept", {160'b0, flat[0 +: 8]}, {160'b0, 8'h3C});
        cs_low();
        shift_bits(8'h28, 8, st);
        shift_bits(8'h00, 8, r0);
        shift_bits(8'h00, 8, r1);
        cs_high();
        check("R7 burst read 0", {160'b0, r0}, {160'b0, 8'h33});
        check("R7 burst read 1", {160'b0, r1}, {160'b0, 8'h33});

        // R9: gp change between bytes of a read burst of reg 20
        gp = 4'h9;
        wclk(6);
        cs_low();
        shift_bits(8'hA0, 8, st);
        shift_bits(8'h00, 8, r0);
        gp = 4'h3;
        shift_bits(8'h00, 8, r1);
        cs_high();
        check("R9 gp before", {160'b0, r0}, {160'b0, 8'h9A});
        check("R9 gp after", {160'b0, r1}, {160'b0, 8'h3A});

        // R10: partial data byte aborted, then a fresh frame
        cs_low();
        shift_bits(8'h1A, 8, st);
        shift_bits(8'hF0, 4, r0);
        cs_high();
        check("R10 partial discarded", {160'b0, flat[3*8 +: 8]}, {160'b0, 8'hA5});
        cs_low();
        shift_bits(8'h1A, 5, r0);
        cs_high();
        cs_low();
        shift_bits(8'h18, 8, st);
        shift_bits(8'h00, 8, r2);
        cs_high();
        check("R10 fresh command", {160'b0, r2}, {160'b0, 8'hA5});

        // R1: reset again mid-run clears the bank
        rst_n = 1'b0;
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        check("R1 reg_flat after second reset", flat, '0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule